// File: doc/BRIEF.md
# CPU Frame Extraction Word Encoder

This block sits between a switch core's CPU-bound frame path and a processor's register interface. Frames arrive one byte per cycle with start, end and abort markers, and a 128-bit internal header is presented on the start beat. The block stores each header in a small header queue and packs payload bytes into 32-bit words in a parameterised word buffer. Software pulls the frame out one word per read strobe from a single read port.

Framing is carried in-band. Eight reserved words from 0x80000000 to 0x80000007 report the end of a frame, a pruned frame, an aborted frame, an escape and an empty queue. A payload word that happens to fall in that range is preceded by the escape code, so software can always tell data from control. The four header words are returned raw and are never escaped, because the reader skips a fixed count of them. A data-present flag tells software when a read will return frame content. A flush input discards everything that is queued.

The buffer holds `BUF_BYTES/4` words. A frame that would overrun the buffer is cut short and reported as pruned. A frame that starts when no header slot is free, or when fewer than two word slots are free, is dropped whole.

Top module: `exf_encoder`

## Requirements
- R1: After reset `data_present` is 0 and `rd_data` is the not-ready word 0x80000007; a read strobe with nothing queued also returns 0x80000007.
- R2: Every accepted frame starts with four header words taken from `in_hdr` on its start beat, bits 127:96 first and bits 31:0 last. They are returned unchanged even if they fall in 0x80000000–0x80000007.
- R3: With byte swap off (`cfg_swap`=0 on the start beat), the first byte of each group of four payload bytes lands in bits 31:24 and the fourth lands in bits 7:0.
- R4: With byte swap on (`cfg_swap`=1 on the start beat), byte order within each payload word is reversed: the first byte lands in bits 7:0. The mode holds for the whole frame.
- R5: A payload word other than a frame's final word whose bits 31:3 equal 0x10000000 (values 0x80000000–0x80000007) is returned as the escape word 0x80000006, then the payload word on the next read.
- R6: A frame of n bytes ends with the word 0x80000000 + ((4 − v) mod 4), where v (1..4) is the number of valid bytes in its last word, followed by that last word with unused bytes zero and no escape.
- R7: An abort marker discards the partial word and the abort byte. Words already stored are returned, then 0x80000005, then one dummy word 0x00000000.
- R8: With the buffer empty when a frame starts, the frame fits if its length is at most BUF_BYTES. Otherwise word number BUF_BYTES/4 (counting from 1) is returned after 0x80000004 as the final word, and the rest of the frame is discarded.
- R9: A read strobe while a frame's body has no stored word returns 0x80000007 and does not advance: the next read after data arrives returns the next word in order.
- R10: `data_present` is 1 while a header is queued or the frame being read has a stored word or a pending word after a control word. It is 0 otherwise, including mid-frame with no stored word.
- R11: A `flush` pulse discards all queued headers, words and any partial frame. `data_present` is 0 in the following cycle, and bytes arriving without a new start marker are ignored.
- R12: A start beat that arrives while HDR_FRAMES headers are queued, or while fewer than two word slots are free, drops the whole frame; queued frames are unaffected.
- R13: `rd_data` changes only at a clock edge where `rd_en` is 1 and `flush` is 0. It then holds the word for that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all queued content |
| in_valid | input | 1 | Byte beat valid |
| in_byte | input | 8 | Payload byte |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_abort | input | 1 | Beat aborts the frame; its byte is discarded |
| in_hdr | input | 128 | Internal header, sampled on the start beat |
| cfg_swap | input | 1 | Byte-swap mode, sampled on the start beat |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_data | output | 32 | Word returned for the latest strobe |
| data_present | output | 1 | Frame content is ready to read |

## Verification
The checker assumes well-formed byte framing: a start marker appears only between frames, and each frame ends with exactly one end or abort beat. It also assumes `flush` is a plain synchronous pulse. The bench drives every frame as an unbroken run of beats that begins with a start beat and closes with a single end or abort beat. The only start-less bytes it sends come right after a flush, where they are meant to be ignored. The pruning check relies on the buffer being empty at the frame's start, so the bench drains every previous frame before it sends an oversized one.

// File: rtl/exf_pkg.sv
package exf_pkg;

   typedef enum logic [1:0] {
      EK_DATA  = 2'd0,
      EK_LAST  = 2'd1,
      EK_PRUNE = 2'd2,
      EK_ABORT = 2'd3
   } ent_kind_e;

   typedef struct packed {
      ent_kind_e   kind;
      logic [1:0]  lb;
      logic [31:0] word;
   } ent_t;

   localparam logic [31:0] CW_EOF   = 32'h8000_0000;
   localparam logic [31:0] CW_PRUNE = 32'h8000_0004;
   localparam logic [31:0] CW_ABORT = 32'h8000_0005;
   localparam logic [31:0] CW_ESC   = 32'h8000_0006;
   localparam logic [31:0] CW_IDLE  = 32'h8000_0007;

   localparam int HDR_WORDS = 4;
   localparam int HDR_BITS  = HDR_WORDS * 32;

   function automatic logic in_ctrl_range(input logic [31:0] w);
      return w[31:3] == 29'h1000_0000;
   endfunction

endpackage

// File: rtl/exf_fifo.sv
module exf_fifo #(
   parameter int W     = 36,
   parameter int DEPTH = 128,
   parameter int CNTW  = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            push,
   input  logic [W-1:0]    din,
   input  logic            pop,
   output logic [W-1:0]    dout,
   output logic [CNTW-1:0] count
);

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] hold;
         logic         full_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      full_q <= 1'b0;
            else if (clr)    full_q <= 1'b0;
            else if (push)   full_q <= 1'b1;
            else if (pop)    full_q <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (push) hold <= din;
         end

         assign dout  = hold;
         assign count = CNTW'(full_q);
      end else begin : g_ring
         localparam int AW = $clog2(DEPTH);
         logic [W-1:0]    mem [DEPTH];
         logic [AW-1:0]   wp, rp;
         logic [CNTW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp  <= '0;
               rp  <= '0;
               cnt <= '0;
            end else if (clr) begin
               wp  <= '0;
               rp  <= '0;
               cnt <= '0;
            end else begin
               if (push) wp <= wp + 1'b1;
               if (pop)  rp <= rp + 1'b1;
               cnt <= cnt + CNTW'(push) - CNTW'(pop);
            end
         end

         always_ff @(posedge clk) begin
            if (push) mem[wp] <= din;
         end

         assign dout  = mem[rp];
         assign count = cnt;
      end
   endgenerate

endmodule

// File: rtl/exf_packer.sv
module exf_packer
   import exf_pkg::*;
#(
   parameter int WORDS        = 128,
   parameter bit SWAP_SUPPORT = 1'b1,
   parameter int CNTW         = $clog2(WORDS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                in_valid,
   input  logic [7:0]          in_byte,
   input  logic                in_sof,
   input  logic                in_eof,
   input  logic                in_abort,
   input  logic                cfg_swap,
   input  logic                hdr_full,
   input  logic [CNTW-1:0]     dat_count,
   output logic                hdr_push,
   output logic                ent_push,
   output ent_t                ent_data
);

   typedef enum logic [1:0] {W_IDLE, W_RUN, W_SKIP} wst_e;

   wst_e        st, st_n;
   logic [1:0]  idx, idx_n, cur_idx, pos;
   logic [31:0] acc, acc_n, cur_acc, merged;
   logic        swap_q, swap_n, swap_eff, cur_swap;
   logic        start, admit, take, room2, term;

   generate
      if (SWAP_SUPPORT) begin : g_swap
         assign swap_eff = cfg_swap;
      end else begin : g_noswap
         assign swap_eff = 1'b0;
      end
   endgenerate

   assign room2    = dat_count <= CNTW'(WORDS - 2);
   assign start    = in_valid && in_sof && (st == W_IDLE);
   assign admit    = start && !hdr_full && room2;
   assign take     = admit || (in_valid && (st == W_RUN));
   assign term     = in_eof || in_abort;
   assign cur_idx  = admit ? 2'd0 : idx;
   assign cur_acc  = admit ? 32'd0 : acc;
   assign cur_swap = admit ? swap_eff : swap_q;
   assign pos      = cur_swap ? cur_idx : (2'd3 - cur_idx);
   assign merged   = cur_acc | ({24'd0, in_byte} << {pos, 3'b000});
   assign hdr_push = admit;

   always_comb begin
      st_n     = st;
      idx_n    = idx;
      acc_n    = acc;
      swap_n   = swap_q;
      ent_push = 1'b0;
      ent_data = '0;
      if (take) begin
         if (admit) swap_n = swap_eff;
         if (in_abort) begin
            ent_push      = 1'b1;
            ent_data.kind = EK_ABORT;
            st_n          = W_IDLE;
            idx_n         = 2'd0;
            acc_n         = 32'd0;
         end else if (in_eof) begin
            ent_push      = 1'b1;
            ent_data.kind = EK_LAST;
            ent_data.lb   = 2'd3 - cur_idx;
            ent_data.word = merged;
            st_n          = W_IDLE;
            idx_n         = 2'd0;
            acc_n         = 32'd0;
         end else if (cur_idx == 2'd3) begin
            ent_push      = 1'b1;
            ent_data.word = merged;
            idx_n         = 2'd0;
            acc_n         = 32'd0;
            if (room2) begin
               ent_data.kind = EK_DATA;
               st_n          = W_RUN;
            end else begin
               ent_data.kind = EK_PRUNE;
               st_n          = W_SKIP;
            end
         end else begin
            acc_n = merged;
            idx_n = cur_idx + 2'd1;
            st_n  = W_RUN;
         end
      end else if (start) begin
         if (!term) st_n = W_SKIP;
      end else if ((st == W_SKIP) && in_valid && term) begin
         st_n = W_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= W_IDLE;
         idx    <= 2'd0;
         acc    <= 32'd0;
         swap_q <= 1'b0;
      end else if (flush) begin
         st     <= W_IDLE;
         idx    <= 2'd0;
         acc    <= 32'd0;
         swap_q <= 1'b0;
      end else begin
         st     <= st_n;
         idx    <= idx_n;
         acc    <= acc_n;
         swap_q <= swap_n;
      end
   end

endmodule

// File: rtl/exf_reader.sv
module exf_reader
   import exf_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                rd_en,
   input  logic                hdr_avail,
   input  logic [HDR_BITS-1:0] hdr_head,
   input  logic                dat_avail,
   input  ent_t                dat_head,
   output logic                hdr_pop,
   output logic                dat_pop,
   output logic [31:0]         rd_data,
   output logic                data_present
);

   typedef enum logic [2:0] {R_IDLE, R_HDR, R_BODY, R_ESC, R_TAIL} rst_e;

   rst_e        st, st_n;
   logic [1:0]  hsel, hsel_n;
   logic [31:0] word_n, hdr_word;
   logic        go, hpop, dpop;

   assign go       = rd_en && !flush;
   assign hdr_word = hdr_head[(HDR_WORDS - 1 - int'(hsel)) * 32 +: 32];

   always_comb begin
      st_n   = st;
      hsel_n = hsel;
      word_n = CW_IDLE;
      hpop   = 1'b0;
      dpop   = 1'b0;
      unique case (st)
         R_IDLE: begin
            if (hdr_avail) begin
               word_n = hdr_word;
               hsel_n = 2'd1;
               st_n   = R_HDR;
            end
         end
         R_HDR: begin
            word_n = hdr_word;
            if (hsel == 2'(HDR_WORDS - 1)) begin
               hpop   = 1'b1;
               hsel_n = 2'd0;
               st_n   = R_BODY;
            end else begin
               hsel_n = hsel + 2'd1;
            end
         end
         R_BODY: begin
            if (dat_avail) begin
               unique case (dat_head.kind)
                  EK_DATA: begin
                     if (in_ctrl_range(dat_head.word)) begin
                        word_n = CW_ESC;
                        st_n   = R_ESC;
                     end else begin
                        word_n = dat_head.word;
                        dpop   = 1'b1;
                     end
                  end
                  EK_LAST: begin
                     word_n = CW_EOF | {30'd0, dat_head.lb};
                     st_n   = R_TAIL;
                  end
                  EK_PRUNE: begin
                     word_n = CW_PRUNE;
                     st_n   = R_TAIL;
                  end
                  default: begin
                     word_n = CW_ABORT;
                     st_n   = R_TAIL;
                  end
               endcase
            end
         end
         R_ESC: begin
            word_n = dat_head.word;
            dpop   = 1'b1;
            st_n   = R_BODY;
         end
         default: begin
            word_n = dat_head.word;
            dpop   = 1'b1;
            st_n   = R_IDLE;
         end
      endcase
   end

   assign hdr_pop = go && hpop;
   assign dat_pop = go && dpop;

   assign data_present = hdr_avail
                      || ((st == R_BODY) && dat_avail)
                      || (st == R_ESC) || (st == R_TAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= R_IDLE;
         hsel    <= 2'd0;
         rd_data <= CW_IDLE;
      end else if (flush) begin
         st      <= R_IDLE;
         hsel    <= 2'd0;
      end else if (rd_en) begin
         st      <= st_n;
         hsel    <= hsel_n;
         rd_data <= word_n;
      end
   end

endmodule

// File: rtl/exf_encoder.sv
module exf_encoder
   import exf_pkg::*;
#(
   parameter int BUF_BYTES    = 512,
   parameter int HDR_FRAMES   = 4,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         in_valid,
   input  logic [7:0]   in_byte,
   input  logic         in_sof,
   input  logic         in_eof,
   input  logic         in_abort,
   input  logic [127:0] in_hdr,
   input  logic         cfg_swap,
   input  logic         rd_en,
   output logic [31:0]  rd_data,
   output logic         data_present
);

   localparam int WORDS = BUF_BYTES / 4;
   localparam int DCW   = $clog2(WORDS + 1);
   localparam int HCW   = $clog2(HDR_FRAMES + 1);
   localparam int EW    = $bits(ent_t);

   generate
      if (BUF_BYTES % 4 != 0) begin : g_bad_bytes
         $error("BUF_BYTES must be a multiple of 4");
      end
      if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("BUF_BYTES/4 must be a power of two of at least 2");
      end
      if (HDR_FRAMES < 1 || (HDR_FRAMES & (HDR_FRAMES - 1)) != 0) begin : g_bad_hdr
         $error("HDR_FRAMES must be a power of two");
      end
   endgenerate

   logic                hdr_push, hdr_pop, hdr_full, hdr_avail;
   logic [HCW-1:0]      hdr_count;
   logic [HDR_BITS-1:0] hdr_head;
   logic                dat_push, dat_pop, dat_avail;
   logic [DCW-1:0]      dat_count;
   ent_t                ent_in, dat_head;
   logic [EW-1:0]       dat_dout;

   assign hdr_full  = hdr_count == HCW'(HDR_FRAMES);
   assign hdr_avail = hdr_count != '0;
   assign dat_avail = dat_count != '0;
   assign dat_head  = ent_t'(dat_dout);

   exf_packer #(
      .WORDS        (WORDS),
      .SWAP_SUPPORT (SWAP_SUPPORT),
      .CNTW         (DCW)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .in_valid  (in_valid),
      .in_byte   (in_byte),
      .in_sof    (in_sof),
      .in_eof    (in_eof),
      .in_abort  (in_abort),
      .cfg_swap  (cfg_swap),
      .hdr_full  (hdr_full),
      .dat_count (dat_count),
      .hdr_push  (hdr_push),
      .ent_push  (dat_push),
      .ent_data  (ent_in)
   );

   exf_fifo #(
      .W     (HDR_BITS),
      .DEPTH (HDR_FRAMES),
      .CNTW  (HCW)
   ) u_hdr_q (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flush),
      .push  (hdr_push),
      .din   (in_hdr),
      .pop   (hdr_pop),
      .dout  (hdr_head),
      .count (hdr_count)
   );

   exf_fifo #(
      .W     (EW),
      .DEPTH (WORDS),
      .CNTW  (DCW)
   ) u_dat_q (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flush),
      .push  (dat_push),
      .din   (ent_in),
      .pop   (dat_pop),
      .dout  (dat_dout),
      .count (dat_count)
   );

   exf_reader u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (flush),
      .rd_en        (rd_en),
      .hdr_avail    (hdr_avail),
      .hdr_head     (hdr_head),
      .dat_avail    (dat_avail),
      .dat_head     (dat_head),
      .hdr_pop      (hdr_pop),
      .dat_pop      (dat_pop),
      .rd_data      (rd_data),
      .data_present (data_present)
   );

endmodule

// File: rtl/exf_encoder_chk.sv
module exf_encoder_chk #(
   parameter int WORDS      = 128,
   parameter int HDR_FRAMES = 4,
   parameter int DCW        = $clog2(WORDS + 1),
   parameter int HCW        = $clog2(HDR_FRAMES + 1)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           flush,
   input logic           rd_en,
   input logic [31:0]    rd_data,
   input logic           data_present,
   input logic           dat_push,
   input logic [DCW-1:0] dat_count,
   input logic           hdr_push,
   input logic [HCW-1:0] hdr_count
);

   // R8: the word buffer is never written while every slot is taken
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dat_push |-> (dat_count != DCW'(WORDS)));

   // R12: a header is never queued into a full header queue
   p_hdr_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_push |-> (hdr_count != HCW'(HDR_FRAMES)));

   // R9: a strobe with nothing ready returns the not-ready word
   p_quiet_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !flush && !data_present) |=> (rd_data == 32'h8000_0007));

   // R11: flush leaves nothing to read
   p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !data_present);

   // R13: the read port holds without a strobe
   p_read_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en || flush) |=> $stable(rd_data));

   // R10: a stored word always makes content visible
   p_present_on_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_push && !flush) |=> data_present);

endmodule

bind exf_encoder exf_encoder_chk #(
   .WORDS      (WORDS),
   .HDR_FRAMES (HDR_FRAMES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flush        (flush),
   .rd_en        (rd_en),
   .rd_data      (rd_data),
   .data_present (data_present),
   .dat_push     (dat_push),
   .dat_count    (dat_count),
   .hdr_push     (hdr_push),
   .hdr_count    (hdr_count)
);

// File: tb/tb_exf_encoder.sv
module tb_exf_encoder;

   localparam int BUF_WORDS = 512 / 4;
   localparam logic [31:0] NRDY = 32'h8000_0007;

   typedef struct packed {
      int         len;
      logic [7:0] seed;
      logic       swap;
   } vec_t;

   localparam vec_t VT [8] = '{
      '{1,   8'h11, 1'b0},
      '{2,   8'h21, 1'b0},
      '{3,   8'h31, 1'b0},
      '{4,   8'h41, 1'b0},
      '{5,   8'h51, 1'b1},
      '{7,   8'h61, 1'b1},
      '{60,  8'h71, 1'b0},
      '{16,  8'h81, 1'b1}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         flush = 1'b0;
   logic         in_valid = 1'b0;
   logic [7:0]   in_byte = 8'd0;
   logic         in_sof = 1'b0;
   logic         in_eof = 1'b0;
   logic         in_abort = 1'b0;
   logic [127:0] in_hdr = '0;
   logic         cfg_swap = 1'b0;
   logic         rd_en = 1'b0;
   logic [31:0]  rd_data;
   logic         data_present;

   int          nchk = 0;
   int          nfail = 0;
   logic [7:0]  fb [0:639];
   logic [31:0] exp_w [0:199];
   int          nexp;
   logic [31:0] w;

   always #5 clk = ~clk;

   exf_encoder dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(in_valid), .in_byte(in_byte), .in_sof(in_sof),
      .in_eof(in_eof), .in_abort(in_abort), .in_hdr(in_hdr),
      .cfg_swap(cfg_swap), .rd_en(rd_en), .rd_data(rd_data),
      .data_present(data_present)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s: got %h exp %h", req, got, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input logic s, input logic e,
                            input logic a, input logic [127:0] h, input logic sw);
      @(negedge clk);
      in_valid = 1'b1; in_byte = b; in_sof = s; in_eof = e; in_abort = a;
      in_hdr = h; cfg_swap = sw;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_abort = 1'b0;
   endtask

   task automatic send_frame(input int len, input logic sw, input logic [127:0] h,
                             input logic ab);
      for (int i = 0; i < len; i++)
         send_byte(fb[i], i == 0, (i == len - 1) && !ab, (i == len - 1) && ab, h, sw);
      idle();
   endtask

   task automatic rd(output logic [31:0] v);
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   function automatic logic [127:0] mk_hdr(input logic [7:0] s);
      return {24'h10_0000, s, 24'h20_0000, s, 24'h30_0000, s, 24'h40_0000, s};
   endfunction

   function automatic logic [31:0] word_of(input int k, input int len, input logic sw);
      logic [31:0] r = '0;
      for (int j = 0; j < 4; j++) begin
         int p = sw ? j : 3 - j;
         if (4 * k + j < len) r[8 * p +: 8] = fb[4 * k + j];
      end
      return r;
   endfunction

   // Expected stream from R2..R6 and R8 (buffer assumed empty at frame start)
   task automatic build(input int len, input logic sw, input logic [127:0] h);
      int nw = (len + 3) / 4;
      nexp = 0;
      for (int i = 0; i < 4; i++) begin
         exp_w[nexp] = h[127 - 32 * i -: 32];
         nexp++;
      end
      for (int k = 0; k < nw; k++) begin
         logic [31:0] v = word_of(k, len, sw);
         if (k == nw - 1) begin
            int vb = len - 4 * k;
            exp_w[nexp] = 32'h8000_0000 | 32'((4 - vb) % 4); nexp++;
            exp_w[nexp] = v; nexp++;
         end else if (k == BUF_WORDS - 1) begin
            exp_w[nexp] = 32'h8000_0004; nexp++;
            exp_w[nexp] = v; nexp++;
            break;
         end else begin
            if (v[31:3] == 29'h1000_0000) begin
               exp_w[nexp] = 32'h8000_0006; nexp++;
            end
            exp_w[nexp] = v; nexp++;
         end
      end
   endtask

   task automatic drain(input string req);
      logic [31:0] v;
      for (int i = 0; i < nexp; i++) begin
         rd(v);
         chk(req, v, exp_w[i]);
      end
      rd(v);
      chk("R9 after frame", v, NRDY);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: got hung exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 present", {31'd0, data_present}, 32'd0);
      chk("R1 rd_data", rd_data, NRDY);
      rd(w);
      chk("R1 empty read", w, NRDY);

      // Table walk: R3 R4 R6 R2
      for (int t = 0; t < 8; t++) begin
         for (int i = 0; i < VT[t].len; i++) fb[i] = VT[t].seed + 8'(i);
         send_frame(VT[t].len, VT[t].swap, mk_hdr(VT[t].seed), 1'b0);
         chk("R10 present", {31'd0, data_present}, 32'd1);
         build(VT[t].len, VT[t].swap, mk_hdr(VT[t].seed));
         drain(VT[t].swap ? "R4/R6" : "R3/R6");
         chk("R10 idle", {31'd0, data_present}, 32'd0);
      end

      // R5 escape and R2 raw header in control range
      begin
         logic [7:0] pat [16] = '{8'h80,8'h00,8'h00,8'h03, 8'h80,8'h00,8'h00,8'h06,
                                  8'h12,8'h34,8'h56,8'h78, 8'h80,8'h00,8'h00,8'h01};
         logic [127:0] h = {32'h8000_0005, 32'h8000_0006, 32'h1, 32'h8000_0007};
         for (int i = 0; i < 16; i++) fb[i] = pat[i];
         send_frame(16, 1'b0, h, 1'b0);
         build(16, 1'b0, h);
         chk("R5 escape expected", exp_w[4], 32'h8000_0006);
         drain("R5/R2");
      end

      // R7 abort, with R13 hold mid-stream
      for (int i = 0; i < 6; i++) fb[i] = 8'hC0 + 8'(i);
      send_frame(6, 1'b0, mk_hdr(8'hA7), 1'b1);
      rd(w);
      chk("R2 first hdr", w, mk_hdr(8'hA7) >> 96);
      repeat (3) @(negedge clk);
      chk("R13 hold", rd_data, mk_hdr(8'hA7) >> 96);
      for (int i = 1; i < 4; i++) begin
         rd(w);
         chk("R2 hdr", w, 32'(mk_hdr(8'hA7) >> (96 - 32 * i)));
      end
      rd(w); chk("R7 word", w, 32'hC0C1C2C3);
      rd(w); chk("R7 code", w, 32'h8000_0005);
      rd(w); chk("R7 dummy", w, 32'h0);
      rd(w); chk("R9 after abort", w, NRDY);

      // R8 boundary: exactly buffer size fits, one more byte prunes
      for (int i = 0; i < 520; i++) fb[i] = 8'(i * 7 + 3);
      send_frame(512, 1'b0, mk_hdr(8'h55), 1'b0);
      build(512, 1'b0, mk_hdr(8'h55));
      drain("R8 fit");
      send_frame(513, 1'b0, mk_hdr(8'h56), 1'b0);
      build(513, 1'b0, mk_hdr(8'h56));
      chk("R8 prune code", exp_w[nexp - 2], 32'h8000_0004);
      drain("R8 pruned");

      // R9/R10 body empty mid-frame
      for (int i = 0; i < 5; i++) fb[i] = 8'h90 + 8'(i);
      build(5, 1'b0, mk_hdr(8'h99));
      send_byte(fb[0], 1'b1, 1'b0, 1'b0, mk_hdr(8'h99), 1'b0);
      send_byte(fb[1], 1'b0, 1'b0, 1'b0, mk_hdr(8'h99), 1'b0);
      idle();
      for (int i = 0; i < 4; i++) begin
         rd(w);
         chk("R2 partial hdr", w, exp_w[i]);
      end
      chk("R10 mid-frame empty", {31'd0, data_present}, 32'd0);
      rd(w); chk("R9 stall", w, NRDY);
      rd(w); chk("R9 stall again", w, NRDY);
      send_byte(fb[2], 1'b0, 1'b0, 1'b0, '0, 1'b0);
      send_byte(fb[3], 1'b0, 1'b0, 1'b0, '0, 1'b0);
      send_byte(fb[4], 1'b0, 1'b1, 1'b0, '0, 1'b0);
      idle();
      chk("R10 resumed", {31'd0, data_present}, 32'd1);
      for (int i = 4; i < nexp; i++) begin
         rd(w);
         chk("R9 resume", w, exp_w[i]);
      end

      // R12 header queue full: fifth frame dropped
      for (int f = 0; f < 5; f++) begin
         for (int i = 0; i < 4; i++) fb[i] = 8'(f * 16 + i + 1);
         send_frame(4, 1'b0, mk_hdr(8'(f + 1)), 1'b0);
      end
      for (int f = 0; f < 4; f++) begin
         for (int i = 0; i < 4; i++) fb[i] = 8'(f * 16 + i + 1);
         build(4, 1'b0, mk_hdr(8'(f + 1)));
         for (int i = 0; i < nexp; i++) begin
            rd(w);
            chk("R12 queued", w, exp_w[i]);
         end
      end
      rd(w); chk("R12 dropped", w, NRDY);

      // R11 flush of a whole frame and of a partial one
      for (int i = 0; i < 8; i++) fb[i] = 8'hE0 + 8'(i);
      send_frame(8, 1'b0, mk_hdr(8'hEE), 1'b0);
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      chk("R11 present", {31'd0, data_present}, 32'd0);
      rd(w); chk("R11 read", w, NRDY);
      send_byte(8'h01, 1'b1, 1'b0, 1'b0, mk_hdr(8'hEF), 1'b0);
      send_byte(8'h02, 1'b0, 1'b0, 1'b0, '0, 1'b0);
      idle();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      for (int i = 0; i < 4; i++)
         send_byte(8'h10 + 8'(i), 1'b0, i == 3, 1'b0, '0, 1'b0);
      idle();
      chk("R11 stray bytes", {31'd0, data_present}, 32'd0);
      rd(w); chk("R11 stray read", w, NRDY);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule